// File: doc/BRIEF.md
# Little-endian byte-addressed memory

A synchronous memory organised as an array of single-byte locations. One port
accepts a byte, a 16-bit word or a 32-bit doubleword per cycle. A multi-byte
write is spread across consecutive locations with the least significant byte
at the given address. A multi-byte read gathers those locations back into one
value in the same order.

The address port is 20 bits wide, enough for the full 1M-byte real-mode space.
Only `DEPTH` locations are built, and `DEPTH` must be a power of two and at
least 4. Upper address bits alias onto the built range. An access that runs
past the last location continues at location 0.

Reads are registered, and data appears in the cycle after the strobe. A
request with the unused size code is refused and flagged.

Top module: `lemem_top`

## Requirements
- R1: Each location holds one byte. A byte write (size 2'b00) changes only the addressed location, and its neighbours keep their contents.
- R2: A word write (size 2'b01) of value V at address A stores V[7:0] at A and V[15:8] at A+1. For example, 1234h gives 34h at A and 12h at A+1.
- R3: A doubleword write (size 2'b10) stores its four bytes at A..A+3, least significant first. For example, 56781234h gives 34h, 12h, 78h, 56h.
- R4: A read of size byte, word or doubleword returns the byte at A in bits 7:0, A+1 in 15:8, A+2 in 23:16 and A+3 in 31:24. Bytes beyond the requested size read as zero.
- R5: `rvalid_o` is high exactly in the cycle after a read strobe with a legal size. `rdata_o` is zero whenever `rvalid_o` is low.
- R6: Size code 2'b11 writes nothing and gives no read valid. `err_o` goes high in the following cycle if the read or write enable was set.
- R7: A multi-byte access whose bytes pass location DEPTH-1 continues at location 0.
- R8: A read and a write in the same cycle to overlapping locations return the contents from before the write.
- R9: Address bits at and above log2(DEPTH) are ignored, so addresses that differ only there reach the same location.
- R10: After reset, `rvalid_o`, `err_o` and `rdata_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 20 | Byte address of the lowest byte of the access |
| size_i | input | 2 | 00 byte, 01 word, 10 doubleword, 11 illegal |
| wr_en_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data, least significant byte first in memory |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, zero-filled above the access size |
| rvalid_o | output | 1 | Read data valid, one cycle after the strobe |
| err_o | output | 1 | Illegal size seen in the previous cycle |

## Verification
Directed writes of 1234h and 56781234h are followed by byte-wide reads of each
location. This separates true little-endian scattering from a byte-swapped or
word-wide layout, and a neighbour read catches over-wide writes. Accesses
placed at the last locations and at aliased high addresses separate correct
wrap and truncation from carry into upper bits. Same-cycle read and write
pairs show whether the read path sees old or new contents. Random mixes of
size, address and enables, including the illegal size, are checked against a
bench byte model for data, valid, zero fill and the error flag.

// File: rtl/lemem_pkg.sv
package lemem_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_DWRD = 2'b10,
    SZ_BAD  = 2'b11
  } size_e;

  localparam int unsigned LANES = 4;
  localparam int unsigned LANE_W = 8;
endpackage

// File: rtl/lemem_lane_map.sv
module lemem_lane_map
  import lemem_pkg::*;
#(
  parameter int unsigned AW    = 20,
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic [AW-1:0]            addr_i,
  input  logic [1:0]               size_i,
  output logic [LANES-1:0][IW-1:0] idx_o,
  output logic [LANES-1:0]         lane_en_o,
  output logic                     size_ok_o
);
  logic [IW-1:0] base;
  logic          unused_hi;

  assign base      = addr_i[IW-1:0];
  assign unused_hi = ^addr_i[AW-1:IW];

  // power-of-two depth: truncated sum is the wrap to 0
  for (genvar k = 0; k < LANES; k++) begin : g_idx
    assign idx_o[k] = base + IW'(k);
  end

  always_comb begin
    unique case (size_e'(size_i))
      SZ_BYTE: lane_en_o = 4'b0001;
      SZ_WORD: lane_en_o = 4'b0011;
      SZ_DWRD: lane_en_o = 4'b1111;
      default: lane_en_o = 4'b0000;
    endcase
    size_ok_o = (size_i != SZ_BAD);
  end
endmodule

// File: rtl/lemem_byte_array.sv
module lemem_byte_array
  import lemem_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic                         clk_i,
  input  logic [LANES-1:0]             we_i,
  input  logic [LANES-1:0][IW-1:0]     idx_i,
  input  logic [LANES-1:0][LANE_W-1:0] wbyte_i,
  output logic [LANES-1:0][LANE_W-1:0] rbyte_o
);
  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    for (int k = 0; k < LANES; k++) begin
      if (we_i[k]) mem[idx_i[k]] <= wbyte_i[k];
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_rd
    assign rbyte_o[k] = mem[idx_i[k]];
  end
endmodule

// File: rtl/lemem_top.sv
module lemem_top
  import lemem_pkg::*;
#(
  parameter int unsigned AW    = 20,
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned IW   = $clog2(DEPTH),
  localparam int unsigned DW   = LANES * LANE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    size_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o,
  output logic          err_o
);
  logic [LANES-1:0][IW-1:0]     idx;
  logic [LANES-1:0]             lane_en;
  logic                         size_ok;
  logic [LANES-1:0][LANE_W-1:0] wbyte, rbyte, rmask;

  lemem_lane_map #(.AW(AW), .DEPTH(DEPTH)) u_map (
    .addr_i   (addr_i),
    .size_i   (size_i),
    .idx_o    (idx),
    .lane_en_o(lane_en),
    .size_ok_o(size_ok)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign wbyte[k] = wdata_i[k*LANE_W +: LANE_W];
    assign rmask[k] = lane_en[k] ? rbyte[k] : '0;
  end

  lemem_byte_array #(.DEPTH(DEPTH)) u_arr (
    .clk_i  (clk_i),
    .we_i   (lane_en & {LANES{wr_en_i}}),
    .idx_i  (idx),
    .wbyte_i(wbyte),
    .rbyte_o(rbyte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      rvalid_o <= rd_en_i & size_ok;
      err_o    <= (rd_en_i | wr_en_i) & ~size_ok;
      rdata_o  <= (rd_en_i & size_ok) ? rmask : '0;
    end
  end

  p_rvalid_after_strobe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && size_i != SZ_BAD) |=> rvalid_o);
  p_no_valid_unasked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rvalid_o);
  p_idle_data_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_o |-> rdata_o == '0);
  p_bad_size_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_en_i || wr_en_i) && size_i == SZ_BAD) |=> (err_o && !rvalid_o));
  p_byte_zero_fill_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && size_i == SZ_BYTE) |=> rdata_o[DW-1:LANE_W] == '0);
  p_word_zero_fill_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && size_i == SZ_WORD) |=> rdata_o[DW-1:2*LANE_W] == '0);
endmodule

// File: tb/sim_lemem_top.sv
`timescale 1ns/1ps
module sim_lemem_top;
  localparam int DEPTH = 1024;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [1:0]    size = '0;
  logic          we = 1'b0, re = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          rvalid, err;

  int n_chk = 0, n_fail = 0;
  logic [7:0] model [DEPTH];
  bit done = 0;

  always #2.5 clk = ~clk;

  lemem_top #(.AW(AW), .DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .size_i(size),
    .wr_en_i(we), .wdata_i(wdata), .rd_en_i(re),
    .rdata_o(rdata), .rvalid_o(rvalid), .err_o(err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [1:0] s);
    return (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : (s == 2'b10) ? 4 : 0;
  endfunction

  function automatic logic [31:0] exp_read(input logic [AW-1:0] a, input logic [1:0] s);
    logic [31:0] v = '0;
    for (int k = 0; k < nbytes(s); k++)
      v[k*8 +: 8] = model[(int'(a) + k) % DEPTH];
    return v;
  endfunction

  // one access; outputs checked in the following cycle
  task automatic access(input logic [AW-1:0] a, input logic [1:0] s, input logic w,
                        input logic [31:0] d, input logic r, input string req);
    logic [31:0] er;
    logic ev, ee;
    @(negedge clk);
    addr = a; size = s; we = w; wdata = d; re = r;
    ev = r && s != 2'b11;
    ee = (r || w) && s == 2'b11;
    er = ev ? exp_read(a, s) : 32'h0;
    if (w) for (int k = 0; k < nbytes(s); k++)
      model[(int'(a) + k) % DEPTH] = d[k*8 +: 8];
    @(negedge clk);
    we = 0; re = 0;
    check({req, " rvalid"}, {31'h0, rvalid}, {31'h0, ev});
    check({req, " err"}, {31'h0, err}, {31'h0, ee});
    check({req, " rdata"}, rdata, er);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    check("R10 rvalid", {31'h0, rvalid}, 32'h0);
    check("R10 err", {31'h0, err}, 32'h0);
    check("R10 rdata", rdata, 32'h0);
    rst_ni = 1'b1;
    // clear the array through the port so the model matches
    for (int i = 0; i < DEPTH; i += 4) access(AW'(i), 2'b10, 1, 32'h0, 0, "init");

    access(20'h00100, 2'b01, 1, 32'h00001234, 0, "R2 wr");
    access(20'h00100, 2'b00, 0, 0, 1, "R2 lo byte 34");
    access(20'h00101, 2'b00, 0, 0, 1, "R2 hi byte 12");
    access(20'h00200, 2'b10, 1, 32'h56781234, 0, "R3 wr");
    for (int k = 0; k < 4; k++) access(AW'(20'h00200 + k), 2'b00, 0, 0, 1, "R3 byte");
    access(20'h00201, 2'b01, 0, 0, 1, "R4 word 7812");
    access(20'h00200, 2'b10, 0, 0, 1, "R4 dword");
    access(20'h00300, 2'b10, 1, 32'hAABBCCDD, 0, "R1 fill");
    access(20'h00301, 2'b00, 1, 32'hFFFFFF5A, 0, "R1 byte wr");
    access(20'h00300, 2'b10, 0, 0, 1, "R1 neighbours");
    access(AW'(DEPTH - 2), 2'b10, 1, 32'h11223344, 0, "R7 wrap wr");
    access(20'h00000, 2'b01, 0, 0, 1, "R7 low locs");
    access(AW'(DEPTH - 1), 2'b10, 0, 0, 1, "R7 wrap rd");
    access(20'h00200, 2'b11, 1, 32'hDEADBEEF, 1, "R6 bad size");
    access(20'h00200, 2'b10, 0, 0, 1, "R6 unchanged");
    access(20'h00200, 2'b10, 1, 32'hCAFEF00D, 1, "R8 same cycle");
    access(20'h00200, 2'b10, 0, 0, 1, "R8 after");
    access(20'hF8200, 2'b10, 0, 0, 1, "R9 alias");
    access(20'hA5000, 2'b01, 1, 32'h0000BEEF, 0, "R9 alias wr");
    access(20'h00000, 2'b01, 0, 0, 1, "R9 alias rd");

    void'($urandom(32'd4242));
    for (int i = 0; i < 600; i++) begin
      logic [AW-1:0] a = AW'($urandom);
      logic [1:0] s = 2'($urandom);
      logic w = 1'($urandom);
      logic r = 1'($urandom) | ~w;
      if ($urandom % 4 == 0) a = AW'(DEPTH - 1 - ($urandom % 3));
      access(a, s, w, $urandom, r, "R4 random");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule